// File: doc/BRIEF.md
# Sampled ADC Readout Sequencer

This block paces an external successive-approximation converter and collects its results. A frame counter divides the master clock into fixed frames of one sample each. At the start of every frame the block raises a registered conversion-start strobe, so the strobe edge carries only the jitter of the master clock. The block then keeps the serial clock parked low through the mandatory quiet window while the converter settles. In the short slot that remains before the next frame, it bursts the serial clock at the master rate and shifts in one full result word, most significant bit first.

The converter changes its data line on each falling serial-clock edge, and the block samples it on each rising edge. At the end of the burst the finished word moves into a holding register and a data-ready flag rises. A host then drains the word one byte at a time through an 8-bit port, most significant byte first, with a one-cycle read strobe per byte. If a new word lands before the host has taken the last byte of the previous one, the newer word replaces it and a sticky overrun flag is set.

Top module: `adc_readout_seq`

## Requirements
- R1: Rising edges of `conv_start` come exactly FRAME_CYC (100) master cycles apart.
- R2: `conv_start` is high for exactly STROBE_CYC (2) master cycles per frame. After synchronous reset is released, the first rising clock edge starts a frame and raises `conv_start`.
- R3: `ser_clk` makes no pulse during the QUIET_CYC (65) cycles that start at the `conv_start` rising edge. Its first rising edge falls on the clock edge 65 cycles after that rising edge.
- R4: Each frame has exactly NBITS (32) `ser_clk` pulses, one per master cycle with no gaps. The last rising edge comes 4 cycles before the next `conv_start` rising edge.
- R5: The word is built from `ser_din` sampled on the rising edges of `ser_clk`. The first bit sampled becomes bit 31, and the word read out equals the word the converter sent.
- R6: `data_rdy` rises on the clock edge after the last bit is sampled. At that point `byte_q` shows bits 31:24. Each `byte_rd` pulse while `data_rdy` is high advances `byte_q` to bits 23:16, then 15:8, then 7:0. The fourth pulse clears `data_rdy`.
- R7: A `byte_rd` pulse while `data_rdy` is low has no effect: `data_rdy` stays low, `byte_q` is unchanged, and the next word starts with bits 31:24.
- R8: If a word completes while `data_rdy` is still high, `overrun` goes to 1 and stays there until reset. The new word replaces the old one, and `byte_q` restarts at bits 31:24.
- R9: While `rst` is high, `conv_start`, `ser_clk`, `data_rdy` and `overrun` are all low. This holds even when reset is asserted in the middle of a serial burst.
- R10: If the fourth `byte_rd` lands on the same edge that completes a new word, the new word is presented with `data_rdy` high and `overrun` is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; one cycle is one frame slot |
| rst | input | 1 | Synchronous reset, active high |
| ser_din | input | 1 | Serial result data from the converter |
| byte_rd | input | 1 | Host byte read strobe, one cycle per byte |
| conv_start | output | 1 | Registered conversion-start strobe |
| ser_clk | output | 1 | Serial clock, pulses only during the readout slot |
| data_rdy | output | 1 | A complete word is waiting for the host |
| overrun | output | 1 | Sticky: a word arrived before the previous one was drained |
| byte_q | output | 8 | Current byte of the held word |

## Verification
A behavioural converter model supplies one word per frame. The words are chosen to separate distinct faults. A lone set bit at each end exposes bit-order or byte-order reversal. All-ones and all-zeros words show a stuck data line or a missing first or last sample. Alternating and irregular words catch a shift that is off by one position. Independent timing monitors measure each frame's period, strobe width, quiet gap and burst length against the clock. Directed cases cover idle reads, an overrun after a partial drain, a final read on the completion edge, and a reset in mid-burst.

// File: rtl/adc_readout_seq.sv
`timescale 1ns/1ps
module adc_readout_seq #(
  parameter int FRAME_CYC  = 100,
  parameter int QUIET_CYC  = 65,
  parameter int NBITS      = 32,
  parameter int STROBE_CYC = 2,
  parameter int BYTE_W     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_din,
  input  logic              byte_rd,
  output logic              conv_start,
  output logic              ser_clk,
  output logic              data_rdy,
  output logic              overrun,
  output logic [BYTE_W-1:0] byte_q
);
  localparam int CW     = $clog2(FRAME_CYC);
  localparam int NBYTES = NBITS / BYTE_W;
  localparam int IW     = $clog2(NBYTES);
  localparam int LAST   = QUIET_CYC + NBITS - 1;

  logic [CW-1:0]    cnt, cnt_nxt;
  logic             sck_en;
  logic [NBITS-1:0] shreg, hold, view;
  logic [IW-1:0]    idx;
  logic             done, last_rd;

  assign cnt_nxt = (cnt == CW'(FRAME_CYC - 1)) ? '0 : cnt + 1'b1;
  assign done    = (cnt == CW'(LAST));
  assign last_rd = byte_rd && (idx == IW'(NBYTES - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt        <= CW'(FRAME_CYC - 1);
      conv_start <= 1'b0;
    end else begin
      cnt        <= cnt_nxt;
      conv_start <= (cnt_nxt < CW'(STROBE_CYC));
    end
  end

  // enable changes only while clk is low, so the gated pulse is whole
  always_ff @(negedge clk) begin
    if (rst) sck_en <= 1'b0;
    else     sck_en <= (cnt >= CW'(QUIET_CYC - 1)) && (cnt <= CW'(LAST - 1));
  end

  assign ser_clk = clk & sck_en;

  always_ff @(posedge clk) begin
    if (rst)         shreg <= '0;
    else if (sck_en) shreg <= {shreg[NBITS-2:0], ser_din};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold     <= '0;
      idx      <= '0;
      data_rdy <= 1'b0;
      overrun  <= 1'b0;
    end else if (done) begin
      hold     <= shreg;
      idx      <= '0;
      data_rdy <= 1'b1;
      if (data_rdy && !last_rd) overrun <= 1'b1;
    end else if (byte_rd && data_rdy) begin
      if (last_rd) begin
        idx      <= '0;
        data_rdy <= 1'b0;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end

  assign view   = hold << (32'(idx) * BYTE_W);
  assign byte_q = view[NBITS-1 -: BYTE_W];
endmodule

// File: rtl/adc_readout_seq_chk.sv
`timescale 1ns/1ps
module adc_readout_seq_chk #(
  parameter int FRAME_CYC = 100,
  parameter int QUIET_CYC = 65,
  parameter int NBITS     = 32,
  parameter int BYTE_W    = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              conv_start,
  input logic              ser_clk,
  input logic              data_rdy,
  input logic              overrun,
  input logic              byte_rd,
  input logic [BYTE_W-1:0] byte_q
);
  localparam int PW   = $clog2(FRAME_CYC) + 2;
  localparam int LAST = QUIET_CYC + NBITS - 1;

  logic          cs_d, seen;
  logic [PW-1:0] pos, ph;
  logic          rise, seen_now, in_slot;

  assign rise     = conv_start && !cs_d;
  assign ph       = rise ? '0 : pos;
  assign seen_now = seen || rise;
  assign in_slot  = (ph >= PW'(QUIET_CYC)) && (ph <= PW'(LAST));

  always_ff @(negedge clk) begin
    if (rst) begin
      cs_d <= 1'b0;
      seen <= 1'b0;
      pos  <= '0;
    end else begin
      cs_d <= conv_start;
      if (rise) seen <= 1'b1;
      pos  <= (ph == '1) ? ph : ph + 1'b1;
    end
  end

  AST_STROBE_HOLD: assert property (@(posedge clk) disable iff (rst)
    $rose(conv_start) |=> conv_start);                                   // R2
  AST_STROBE_END: assert property (@(posedge clk) disable iff (rst)
    (conv_start && $past(conv_start)) |=> !conv_start);                 // R2
  AST_QUIET_WINDOW: assert property (@(negedge clk) disable iff (rst)
    (ser_clk && seen_now) |-> in_slot);                                 // R3
  AST_BURST_FULL: assert property (@(negedge clk) disable iff (rst)
    (seen_now && in_slot) |-> ser_clk);                                 // R4
  AST_IDLE_READ: assert property (@(posedge clk) disable iff (rst)
    (!data_rdy && byte_rd) |=> ($stable(byte_q) || data_rdy));          // R7
  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);                                               // R8
endmodule

bind adc_readout_seq adc_readout_seq_chk #(
  .FRAME_CYC(FRAME_CYC), .QUIET_CYC(QUIET_CYC), .NBITS(NBITS), .BYTE_W(BYTE_W)
) u_chk (
  .clk(clk), .rst(rst), .conv_start(conv_start), .ser_clk(ser_clk),
  .data_rdy(data_rdy), .overrun(overrun), .byte_rd(byte_rd), .byte_q(byte_q)
);

// File: tb/tb_adc_readout_seq.sv
`timescale 1ns/1ps
module tb_adc_readout_seq;
  localparam int  FRAME = 100;
  localparam int  QUIET = 65;
  localparam int  NB    = 32;
  localparam real PER   = 5.0;
  localparam int  NW    = 6;
  localparam logic [31:0] WORDS [NW] = '{
    32'h8000_0001, 32'hFFFF_FFFF, 32'h0000_0000,
    32'h1234_5678, 32'hA5C3_3C5A, 32'h7FFF_FFFE };

  logic clk = 1'b0, rst = 1'b1, byte_rd = 1'b0;
  wire  ser_din, conv_start, ser_clk, data_rdy, overrun;
  wire [7:0] byte_q;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  adc_readout_seq dut (
    .clk(clk), .rst(rst), .ser_din(ser_din), .byte_rd(byte_rd),
    .conv_start(conv_start), .ser_clk(ser_clk), .data_rdy(data_rdy),
    .overrun(overrun), .byte_q(byte_q));

  function automatic logic [31:0] adc_word(int f);
    if (f < NW) return WORDS[f];
    return {f[7:0] ^ 8'h5A, ~f[7:0], f[7:0], 8'hC3};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // behavioural converter: new word at each strobe, next bit after each falling serial edge
  int k = 0;
  logic [31:0] adc_sh = '0;
  assign ser_din = adc_sh[31];
  always @(posedge conv_start) begin adc_sh = adc_word(k); k++; end
  always @(negedge ser_clk) adc_sh = adc_sh << 1;

  // frame timing monitor
  bit mon_en = 0, have_prev = 0;
  realtime t_cnv = 0, t_first = 0, t_last = 0;
  int n_sck = 0;
  always @(posedge ser_clk) begin
    if (n_sck == 0) t_first = $realtime;
    t_last = $realtime;
    n_sck++;
  end
  always @(posedge conv_start) begin
    if (mon_en && have_prev) begin
      check(int'(($realtime - t_cnv) / PER) == FRAME, "R1 frame period", int'(($realtime - t_cnv) / PER), FRAME);
      check(n_sck == NB, "R4 pulse count", n_sck, NB);
      check(int'((t_first - t_cnv) / PER) == QUIET, "R3 quiet gap", int'((t_first - t_cnv) / PER), QUIET);
      check(int'(($realtime - t_last) / PER) == 4, "R4 tail gap", int'(($realtime - t_last) / PER), 4);
    end
    have_prev = mon_en;
    t_cnv = $realtime;
    n_sck = 0;
  end
  always @(negedge conv_start)
    if (mon_en && have_prev)
      check(int'(($realtime - t_cnv) / PER) == 2, "R2 strobe width", int'(($realtime - t_cnv) / PER), 2);

  task automatic tick; @(posedge clk); #1; endtask

  task automatic wait_rdy(output bit ok);
    ok = 0;
    for (int i = 0; i < 300; i++) begin
      if (data_rdy) begin ok = 1; return; end
      tick;
    end
  endtask

  task automatic read_bytes(input logic [31:0] exp, input int n, input string req);
    for (int b = 0; b < n; b++) begin
      check(byte_q == exp[31 - 8*b -: 8], req, byte_q, exp[31 - 8*b -: 8]);
      byte_rd = 1'b1; tick; byte_rd = 1'b0;
    end
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary;
    $finish;
  end

  initial begin
    bit ok;
    logic [31:0] exp, exp2;
    repeat (4) tick;
    // R9: reset state, sampled inside the high phase of clk
    check(conv_start == 0, "R9 strobe in reset", conv_start, 0);
    check(ser_clk == 0, "R9 serial clock in reset", ser_clk, 0);
    check(data_rdy == 0, "R9 ready in reset", data_rdy, 0);
    check(overrun == 0, "R9 overrun in reset", overrun, 0);
    mon_en = 1;
    rst = 1'b0;
    tick; check(conv_start == 1, "R2 first edge after reset", conv_start, 1);
    tick; check(conv_start == 1, "R2 second strobe cycle", conv_start, 1);
    tick; check(conv_start == 0, "R2 strobe ends", conv_start, 0);

    // vector table: each frame's word read back byte by byte (R5, R6)
    for (int i = 0; i < NW; i++) begin
      wait_rdy(ok);
      check(ok, "R6 ready rises", ok, 1);
      read_bytes(WORDS[i], 4, "R5 byte order");
      check(data_rdy == 0, "R6 ready clears after fourth byte", data_rdy, 0);
      check(overrun == 0, "R8 no overrun when drained", overrun, 0);
    end

    // R7: reads while idle are ignored
    byte_rd = 1'b1; repeat (3) tick; byte_rd = 1'b0;
    check(data_rdy == 0, "R7 idle read keeps ready low", data_rdy, 0);
    check(byte_q == WORDS[NW-1][31:24], "R7 idle read leaves byte", byte_q, WORDS[NW-1][31:24]);
    wait_rdy(ok);
    exp = adc_word(k - 1);
    check(byte_q == exp[31:24], "R7 next word starts at top byte", byte_q, exp[31:24]);
    read_bytes(exp, 4, "R5 word after idle reads");

    // R10: fourth read on the completion edge
    wait_rdy(ok);
    exp = adc_word(k - 1);
    read_bytes(exp, 3, "R10 first three bytes");
    repeat (96) @(posedge clk);
    #1 byte_rd = 1'b1; tick; byte_rd = 1'b0;
    exp2 = adc_word(k - 1);
    check(data_rdy == 1, "R10 new word ready", data_rdy, 1);
    check(overrun == 0, "R10 no overrun", overrun, 0);
    check(byte_q == exp2[31:24], "R10 new word top byte", byte_q, exp2[31:24]);
    read_bytes(exp2, 4, "R10 new word bytes");

    // R8: overrun after a partial drain
    wait_rdy(ok);
    exp = adc_word(k - 1);
    read_bytes(exp, 2, "R8 partial drain");
    for (int i = 0; i < 200 && !overrun; i++) tick;
    exp2 = adc_word(k - 1);
    check(overrun == 1, "R8 overrun set", overrun, 1);
    check(data_rdy == 1, "R8 ready held", data_rdy, 1);
    check(byte_q == exp2[31:24], "R8 index restarts on newer word", byte_q, exp2[31:24]);
    read_bytes(exp2, 4, "R8 newer word bytes");
    check(data_rdy == 0, "R8 ready clears", data_rdy, 0);
    check(overrun == 1, "R8 overrun sticky", overrun, 1);

    // R9: reset in the middle of a burst
    for (int i = 0; i < 200 && !ser_clk; i++) tick;
    check(ser_clk == 1, "R9 burst reached", ser_clk, 1);
    mon_en = 0; have_prev = 0;
    rst = 1'b1;
    tick; tick;
    check(ser_clk == 0, "R9 serial clock idle in reset", ser_clk, 0);
    check(conv_start == 0, "R9 strobe low in reset", conv_start, 0);
    check(data_rdy == 0, "R9 ready cleared", data_rdy, 0);
    check(overrun == 0, "R9 overrun cleared", overrun, 0);
    mon_en = 1;
    rst = 1'b0;
    tick; check(conv_start == 1, "R2 frame restarts after reset", conv_start, 1);
    for (int f = 0; f < 3; f++) begin
      wait_rdy(ok);
      exp = adc_word(k - 1);
      read_bytes(exp, 4, "R5 after reset");
    end

    summary;
    $finish;
  end
endmodule